// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel that gathers a chain of source buffers into a single contiguous destination region. Each buffer is described by a four-word descriptor in memory. The channel reads descriptors and moves data through one valid/ready memory master port. A data word is read from the source and then written to the destination, so the channel moves at most one word per two accepted memory cycles.

Software first programs two start values through a small write port: the destination start address and the address of the first descriptor. A `go` pulse then starts the chain. For each descriptor, the channel copies the buffer and then writes one status word back into that descriptor. It also raises a one-cycle buffer interrupt and moves on to the descriptor at the next pointer, without waiting for the interrupt to be serviced. Descriptors reload only the source side. The destination pointer keeps running from buffer to buffer, upward or downward. The chain ends on a zero next pointer, and the channel then pulses `xfer_done` and goes idle.

A descriptor occupies four consecutive 32-bit words at byte offsets +0, +4, +8 and +12. In that order they hold the source address, the control word, the option word and the next-descriptor pointer. The control word carries the buffer length in words in bits 15:0 and the done flag in bit 31. Bit 0 of the option word selects a descending destination.

Top module: `lldma_channel`

## Requirements
- R1: After a `go` pulse in idle, the channel reads the four descriptor words at the head pointer, at byte offsets +0, +4, +8 and +12, before it touches any data.
- R2: For a buffer of length N (control bits 15:0), exactly N words are read from the source, which starts at the descriptor's source address and rises by 4 bytes per word. Each word is written to the destination in the same order.
- R3: The destination pointer is loaded only from the start-value port and is never reloaded from a descriptor. The words of consecutive buffers land back to back in one region.
- R4: When option bit 0 of a descriptor is 1, the destination pointer falls by 4 bytes per word instead of rising.
- R5: After each buffer, the channel writes exactly one word back, to the control word at descriptor offset +4. That word has bit 31 set, bits 15:0 equal to the number of words moved, and bits 30:16 kept from the fetched control word. The other three descriptor words are left unchanged.
- R6: `buf_irq` is a one-cycle pulse, raised once per buffer in the cycle after the writeback is accepted. The channel goes on to the next descriptor without waiting on it.
- R7: When the next pointer of the finished descriptor is zero, `xfer_done` pulses for one cycle and `busy` falls in the following cycle. The last buffer's `buf_irq` falls in the same cycle as `xfer_done`.
- R8: A buffer of length 0 moves no data but still performs its writeback, its interrupt and the next descriptor fetch.
- R9: While `mem_req` is high and `mem_ready` is low, the request, address, write enable and write data hold steady into the next cycle.
- R10: While `busy` is high, start-value writes and `go` pulses have no effect on the running chain.
- R11: During and after reset the channel is idle: `busy`, `buf_irq`, `xfer_done` and `mem_req` are low, and no memory request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Start-value write strobe, taken only while idle |
| cfg_sel | input | 1 | 0 writes the destination start address, 1 writes the head descriptor pointer |
| cfg_wdata | input | 32 | Start-value write data |
| go | input | 1 | Start pulse, taken only while idle |
| busy | output | 1 | High from the start until the chain ends |
| buf_irq | output | 1 | One-cycle pulse per finished buffer |
| xfer_done | output | 1 | One-cycle pulse when the whole chain has ended |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle; read data is valid with it |
| mem_rdata | input | 32 | Memory read data |

## Verification
The per-buffer interrupt and the chain-complete pulse fall in the same cycle whenever the last descriptor's writeback is accepted. The bench provokes this in every chain, including chains whose last buffer is empty. It counts the cycles in which both signals are high, and it expects exactly one such cycle per chain, together with one interrupt per descriptor. The writeback and the start of the next fetch also follow each other with no gap. The bench judges that pair by reading each descriptor in memory after the run. The control word must carry the done flag and the moved length, and the three neighbouring words must be untouched. Runs with a stalling memory check that a request held against a low ready never changes.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

   // channel sequencing states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RD,
      ST_WR,
      ST_WB,
      ST_DONE
   } lldma_st_e;

   // descriptor layout, word indices (writeback and fetch order depend on them)
   localparam int DESC_WORDS = 4;
   localparam int IDX_SRC    = 0;
   localparam int IDX_CTLA   = 1;
   localparam int IDX_CTLB   = 2;
   localparam int IDX_NEXT   = 3;

endpackage

// File: rtl/lldma_addr_step.sv
module lldma_addr_step #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              adv,
   input  logic              down,
   output logic [ADDR_W-1:0] q
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("lldma_addr_step: STEP must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (adv) begin
         q <= down ? (q - STEP_V) : (q + STEP_V);
      end
   end

endmodule

// File: rtl/lldma_desc_regs.sv
module lldma_desc_regs #(
   parameter int DATA_W = 32,
   parameter int NWORDS = 4,
   parameter int FIRST  = 1,
   parameter int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr,
   input  logic [IW-1:0]                        wr_idx,
   input  logic [DATA_W-1:0]                    wr_data,
   output logic [NWORDS-1:FIRST][DATA_W-1:0]    words
);

   if (FIRST < 0 || FIRST >= NWORDS) begin : g_bad_first
      $error("lldma_desc_regs: FIRST out of range");
   end

   for (genvar i = FIRST; i < NWORDS; i++) begin : g_word
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= '0;
         end else if (wr && (wr_idx == IW'(i))) begin
            r <= wr_data;
         end
      end
      assign words[i] = r;
   end

endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
   import lldma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int DONE_BIT   = 31,
   parameter int WORD_BYTES = 4,
   parameter int IW         = $clog2(DESC_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] head_ptr,
   input  logic [DATA_W-1:0] ctla,
   input  logic              dst_down_cfg,
   input  logic [DATA_W-1:0] nxt,
   input  logic [ADDR_W-1:0] src_q,
   input  logic [ADDR_W-1:0] dst_q,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              fetch_wr,
   output logic [IW-1:0]     fetch_idx,
   output logic              src_load,
   output logic              step_adv,
   output logic              dst_down,
   output logic              busy,
   output logic              buf_irq,
   output logic              xfer_done
);

   localparam int SHIFT = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] CTLA_OFS = ADDR_W'(IDX_CTLA * WORD_BYTES);
   localparam logic [IW-1:0]     LAST_IDX = IW'(DESC_WORDS - 1);

   lldma_st_e         st;
   logic [IW-1:0]     widx;
   logic [ADDR_W-1:0] desc_addr;
   logic [SIZE_W-1:0] cnt;
   logic [SIZE_W-1:0] cnt_nx;
   logic [SIZE_W-1:0] size;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] wb_word;
   logic              hs;
   logic              irq_q;

   assign size   = ctla[SIZE_W-1:0];
   assign cnt_nx = cnt + 1'b1;
   assign hs     = mem_req && mem_ready;

   // status word written back into the descriptor
   always_comb begin
      wb_word                = ctla;
      wb_word[SIZE_W-1:0]    = cnt;
      wb_word[DONE_BIT]      = 1'b1;
   end

   // memory port mux
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + (ADDR_W'(widx) << SHIFT);
         end
         ST_RD: begin
            mem_req  = 1'b1;
            mem_addr = src_q;
         end
         ST_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_q;
            mem_wdata = data_q;
         end
         ST_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = desc_addr + CTLA_OFS;
            mem_wdata = wb_word;
         end
         default: ;
      endcase
   end

   assign fetch_wr  = (st == ST_FETCH) && hs;
   assign fetch_idx = widx;
   assign src_load  = fetch_wr && (widx == IW'(IDX_SRC));
   assign step_adv  = (st == ST_WR) && hs;
   assign dst_down  = dst_down_cfg;
   assign busy      = (st != ST_IDLE);
   assign buf_irq   = irq_q;
   assign xfer_done = (st == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         widx      <= '0;
         desc_addr <= '0;
         cnt       <= '0;
         data_q    <= '0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (go) begin
                  desc_addr <= head_ptr;
                  widx      <= '0;
                  st        <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (hs) begin
                  if (widx == LAST_IDX) begin
                     cnt <= '0;
                     st  <= (size == '0) ? ST_WB : ST_RD;
                  end else begin
                     widx <= widx + 1'b1;
                  end
               end
            end
            ST_RD: begin
               if (hs) begin
                  data_q <= mem_rdata;
                  st     <= ST_WR;
               end
            end
            ST_WR: begin
               if (hs) begin
                  cnt <= cnt_nx;
                  st  <= (cnt_nx == size) ? ST_WB : ST_RD;
               end
            end
            ST_WB: begin
               if (hs) begin
                  irq_q <= 1'b1;
                  if (nxt == '0) begin
                     st <= ST_DONE;
                  end else begin
                     desc_addr <= nxt[ADDR_W-1:0];
                     widx      <= '0;
                     st        <= ST_FETCH;
                  end
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // memory requests wait on ready without changing
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // interrupt is a single-cycle pulse
   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq |=> !buf_irq);

   // interrupt only follows an accepted write (the writeback)
   assert_irq_after_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq |-> $past(mem_req && mem_we && mem_ready));

   // chain end returns to idle
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !busy);

   // an idle channel makes no memory requests
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // data steps only after the descriptor has been read in full
   assert_fetch_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !step_adv);

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
   import lldma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int DONE_BIT   = 31,
   parameter int DIR_BIT    = 0,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              go,
   output logic              busy,
   output logic              buf_irq,
   output logic              xfer_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int IW = $clog2(DESC_WORDS);

   if (SIZE_W >= DONE_BIT)                     begin : g_bad_size
      $error("lldma_channel: length field overlaps done flag");
   end
   if (DONE_BIT >= DATA_W || DIR_BIT >= DATA_W) begin : g_bad_bit
      $error("lldma_channel: flag bit outside data word");
   end
   if (ADDR_W > DATA_W)                         begin : g_bad_addr
      $error("lldma_channel: pointers must fit one data word");
   end
   if (WORD_BYTES != (1 << $clog2(WORD_BYTES))) begin : g_bad_word
      $error("lldma_channel: WORD_BYTES must be a power of two");
   end

   logic [ADDR_W-1:0]                       head_ptr;
   logic [DESC_WORDS-1:1][DATA_W-1:0]       desc_w;
   logic [ADDR_W-1:0]                       src_q;
   logic [ADDR_W-1:0]                       dst_q;
   logic                                    fetch_wr;
   logic [IW-1:0]                           fetch_idx;
   logic                                    src_load;
   logic                                    step_adv;
   logic                                    dst_down;
   logic                                    cfg_ok;
   logic                                    unused_ctlb;

   assign cfg_ok      = cfg_we && !busy;
   assign unused_ctlb = ^desc_w[IDX_CTLB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_ptr <= '0;
      end else if (cfg_ok && cfg_sel) begin
         head_ptr <= cfg_wdata[ADDR_W-1:0];
      end
   end

   lldma_desc_regs #(
      .DATA_W (DATA_W),
      .NWORDS (DESC_WORDS),
      .FIRST  (1),
      .IW     (IW)
   ) desc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (fetch_wr),
      .wr_idx  (fetch_idx),
      .wr_data (mem_rdata),
      .words   (desc_w)
   );

   lldma_addr_step #(
      .ADDR_W (ADDR_W),
      .STEP   (WORD_BYTES)
   ) src_step_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (src_load),
      .load_val (mem_rdata[ADDR_W-1:0]),
      .adv      (step_adv),
      .down     (1'b0),
      .q        (src_q)
   );

   lldma_addr_step #(
      .ADDR_W (ADDR_W),
      .STEP   (WORD_BYTES)
   ) dst_step_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_ok && !cfg_sel),
      .load_val (cfg_wdata[ADDR_W-1:0]),
      .adv      (step_adv),
      .down     (dst_down),
      .q        (dst_q)
   );

   lldma_ctrl #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .SIZE_W     (SIZE_W),
      .DONE_BIT   (DONE_BIT),
      .WORD_BYTES (WORD_BYTES),
      .IW         (IW)
   ) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .go           (go),
      .head_ptr     (head_ptr),
      .ctla         (desc_w[IDX_CTLA]),
      .dst_down_cfg (desc_w[IDX_CTLB][DIR_BIT]),
      .nxt          (desc_w[IDX_NEXT]),
      .src_q        (src_q),
      .dst_q        (dst_q),
      .mem_ready    (mem_ready),
      .mem_rdata    (mem_rdata),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .fetch_wr     (fetch_wr),
      .fetch_idx    (fetch_idx),
      .src_load     (src_load),
      .step_adv     (step_adv),
      .dst_down     (dst_down),
      .busy         (busy),
      .buf_irq      (buf_irq),
      .xfer_done    (xfer_done)
   );

   // the destination pointer moves only by one word per accepted data write
   assert_dst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step_adv) |=> $stable(dst_q));

   // start values are frozen while a chain runs
   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(head_ptr));

endmodule

// File: tb/lldma_channel_tb_top.sv
module lldma_channel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic        cfg_sel;
   logic [31:0] cfg_wdata;
   logic        go;
   logic        busy, buf_irq, xfer_done;
   logic        mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   lldma_channel dut_i (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata), .go (go),
      .busy (busy), .buf_irq (buf_irq), .xfer_done (xfer_done),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_ready (mem_ready), .mem_rdata (mem_rdata)
   );

   // memory model: 256 words, bench preload shares the single write block
   logic [31:0] mem [256];
   logic        tb_we;
   logic [7:0]  tb_a;
   logic [31:0] tb_d;
   logic        stall_en;

   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk) begin
      if (tb_we) mem[tb_a] <= tb_d;
      else if (mem_req && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_ready <= 1'b1;
      else        mem_ready <= stall_en ? ~mem_ready : 1'b1;
   end

   // event monitors, sampled mid-cycle
   int irq_cnt = 0, done_cnt = 0, both_cnt = 0, hold_err = 0;
   logic        pend = 1'b0;
   logic [31:0] pa = '0, pd = '0;
   logic        pw = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (buf_irq) irq_cnt++;
         if (xfer_done) done_cnt++;
         if (buf_irq && xfer_done) both_cnt++;
         if (pend && !(mem_req && mem_addr == pa && mem_we == pw && mem_wdata == pd)) hold_err++;
         pend = mem_req && !mem_ready;
         pa = mem_addr; pw = mem_we; pd = mem_wdata;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_a = 8'(a); tb_d = d;
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // vector: [15] descending destination, [14] stalling memory,
   //         [13:12] buffer count, [11:8] [7:4] [3:0] buffer lengths
   localparam logic [15:0] VEC [6] = '{
      16'h1300,   // one buffer of 3
      16'h7425,   // three buffers, stalls
      16'hA610,   // descending, two buffers
      16'h3203,   // empty buffer in the middle
      16'hE040,   // descending, stalls, empty first buffer
      16'h1000    // single empty buffer
   };

   function automatic int len_of(input logic [15:0] v, input int k);
      return int'(v[11 - 4*k -: 4]);
   endfunction

   function automatic logic [31:0] src_word(input int k, input int i);
      return 32'hA000_0000 | (32'(k) << 8) | 32'(i);
   endfunction

   task automatic run_vec(input logic [15:0] v, input bit meddle);
      int nb, total, base, i0, d0, b0;
      bit dec;
      dec = v[15];
      nb  = int'(v[13:12]);
      stall_en = v[14];
      for (int w = 0; w < 256; w++) poke(w, 32'hDEAD_0000 | 32'(w));
      for (int k = 0; k < nb; k++) begin
         poke(16 + 4*k, 32'(256 + 64*k));
         poke(17 + 4*k, 32'h0ABC_0000 | 32'(len_of(v, k)));
         poke(18 + 4*k, 32'h0000_5500 | 32'(dec));
         poke(19 + 4*k, (k == nb - 1) ? 32'h0 : 32'(64 + 16*(k + 1)));
         for (int i = 0; i < len_of(v, k); i++) poke(64 + 16*k + i, src_word(k, i));
      end
      @(negedge clk); tb_we = 1'b0;
      base = dec ? 255 : 128;
      cfg_write(1'b0, 32'(base * 4));
      cfg_write(1'b1, 32'd64);
      i0 = irq_cnt; d0 = done_cnt; b0 = both_cnt;
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
      if (meddle) begin
         repeat (12) @(negedge clk);
         // R10: these must be ignored while busy
         cfg_write(1'b0, 32'h0000_0000);
         cfg_write(1'b1, 32'h0000_0080);
         @(negedge clk); go = 1'b1;
         @(negedge clk); go = 1'b0;
      end
      for (int t = 0; t < 4000 && done_cnt == d0; t++) @(negedge clk);
      @(negedge clk);
      // R1 R2 R3 R4: destination holds the source words in chain order
      total = 0;
      for (int k = 0; k < nb; k++) begin
         for (int i = 0; i < len_of(v, k); i++) begin
            int w;
            w = dec ? base - total : base + total;
            chk(mem[w] == src_word(k, i), "R1 R2 R3 R4 dest word", mem[w], src_word(k, i));
            total++;
         end
      end
      begin
         int g;
         g = dec ? base - total : base + total;
         chk(mem[g] == (32'hDEAD_0000 | 32'(g)), "R2 R8 guard word untouched", mem[g], 32'hDEAD_0000 | 32'(g));
      end
      // R5 R8: writeback of control word only
      for (int k = 0; k < nb; k++) begin
         logic [31:0] e;
         e = 32'h8ABC_0000 | 32'(len_of(v, k));
         chk(mem[17 + 4*k] == e, "R5 R8 control writeback", mem[17 + 4*k], e);
         chk(mem[16 + 4*k] == 32'(256 + 64*k), "R5 source word kept", mem[16 + 4*k], 32'(256 + 64*k));
         chk(mem[18 + 4*k] == (32'h5500 | 32'(dec)), "R5 option word kept", mem[18 + 4*k], 32'h5500 | 32'(dec));
      end
      chk(irq_cnt - i0 == nb, "R6 one interrupt per buffer", 32'(irq_cnt - i0), 32'(nb));
      chk(done_cnt - d0 == 1, "R7 R10 one chain-complete pulse", 32'(done_cnt - d0), 32'd1);
      chk(both_cnt - b0 == 1, "R7 last interrupt with chain end", 32'(both_cnt - b0), 32'd1);
      chk(busy == 1'b0, "R7 idle after chain", 32'(busy), 32'd0);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; go = 1'b0;
      tb_we = 1'b0; tb_a = '0; tb_d = '0; stall_en = 1'b0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!busy && !buf_irq && !xfer_done && !mem_req, "R11 outputs in reset",
          {28'd0, busy, buf_irq, xfer_done, mem_req}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req, "R11 idle after reset", {30'd0, busy, mem_req}, 32'd0);

      foreach (VEC[n]) run_vec(VEC[n], 1'b0);

      // R10: writes and go during a run leave it unchanged
      run_vec(VEC[1], 1'b1);

      // R9: held requests under stalls
      chk(hold_err == 0, "R9 request held while not ready", 32'(hold_err), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule